// File: doc/BRIEF.md
# Power-On and Standby Sequencer

This block drives the power and start-up pins of a small processor system. While the system is off, the processor is held in standby with reset asserted, and the supply regulators are disabled. A wake request sets the on/off latch. The wake comes either from a rising edge on the external wake key input or from the elapsed-time divider's timeout flag. Setting the latch enables the supply at once. The block then takes the processor through a rail-settle phase, a reset phase and the running phase.

Both delays are counted in pulses of a slow timebase tick, normally 32768 Hz, that is supplied as a clock enable. The settle delay defaults to 512 ticks (about 16 ms). The reset phase defaults to 1536 ticks (about 47 ms).

A one-cycle switch-off strobe comes from the processor's access decoder. It returns the system to the off state in a single cycle. It also emits a one-cycle clear to the NMI-enable and pulse-enable latches, so the 1 Hz tick goes back to clocking the elapsed-time counter. Only a power-on cold reset initialises the block.

Top module: `pwr_sequencer`

## Requirements
- R1: While `coldRst` is high and in the cycle after it falls (with no wake input), `supplyOnN`=1, `stbyN`=0, `resN`=0 and `latchClr`=0.
- R2: In the off state, a 0→1 change of `acIn` between two consecutive clock samples makes `supplyOnN`=0 after that clock edge. `stbyN` and `resN` stay 0.
- R3: In the off state, `timeoutFlag`=1 at a clock edge makes `supplyOnN`=0 after that edge, just as in R2.
- R4: In the settle phase (`supplyOnN`=0, `stbyN`=0), `stbyN` rises to 1 at the edge that samples the SETTLE_TICKS-th `tickEn` pulse of that phase. `resN` stays 0.
- R5: In the reset phase (`stbyN`=1, `resN`=0), `resN` rises to 1 at the edge that samples the RESET_TICKS-th `tickEn` pulse of that phase. `resN` never rises unless `stbyN` was already 1.
- R6: `offStrobe`=1 in any on phase makes, after that edge, `supplyOnN`=1, `stbyN`=0, `resN`=0 and `latchClr`=1. `latchClr` returns to 0 one cycle later.
- R7: While on, `acIn` edges and `timeoutFlag` have no effect: the outputs keep their phase. After a later switch-off the system stays off.
- R8: `offStrobe` while off has no effect: `latchClr` stays 0 and the outputs stay off.
- R9: A wake (R2 or R3 condition) sampled in the same cycle as an accepted switch-off is honoured. The system is off for exactly one cycle, then restarts with a full settle phase.
- R10: Holding `acIn` at 1 is not a wake; only its rising edge is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| coldRst | input | 1 | Power-on cold reset, active high |
| tickEn | input | 1 | One-cycle pulse per slow timebase tick |
| acIn | input | 1 | External wake key level, high when pressed |
| timeoutFlag | input | 1 | Elapsed-time divider timeout flag |
| offStrobe | input | 1 | One-cycle switch-off access strobe |
| supplyOnN | output | 1 | Supply enable, active low |
| stbyN | output | 1 | Processor standby pin, low = standby |
| resN | output | 1 | Processor reset pin, low = reset |
| latchClr | output | 1 | One-cycle clear for NMI-enable and pulse-enable latches |

## Verification
The bench counts the timebase pulses seen in each phase.

- A design whose timer is off by one would release standby or reset one tick early or late.
- A design that did not capture a wake coinciding with a switch-off would stay off forever.
- A level-sensitive wake would restart the system straight after every switch-off while the key is held.
- A design that let the wake key act while on would restart or hold the sequence.
- Random stretches of wake, timeout and switch-off traffic, with irregular ticks, are compared cycle by cycle against a bench model of the phases.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_SETTLE = 2'd1,
    PS_HOLD   = 2'd2,
    PS_RUN    = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 512,
  parameter int unsigned RESET_TICKS  = 1536
) (
  input  logic       clk,
  input  logic       coldRst,
  input  seqStrobe_t strb,
  input  logic       acIn,
  output logic       acRise,
  output logic       settleHit,
  output logic       holdHit
);
  localparam int unsigned MAX_TICKS = (SETTLE_TICKS > RESET_TICKS) ? SETTLE_TICKS : RESET_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] tickCnt;
  logic             acPrev;

  always_ff @(posedge clk) begin
    if (coldRst) begin
      tickCnt <= '0;
      acPrev  <= 1'b0;
    end else begin
      acPrev <= acIn;
      if (strb.cntClr)      tickCnt <= '0;
      else if (strb.cntInc) tickCnt <= tickCnt + 1'b1;
    end
  end

  assign acRise    = acIn & ~acPrev;
  assign settleHit = (tickCnt == CNT_W'(SETTLE_TICKS - 1));
  assign holdHit   = (tickCnt == CNT_W'(RESET_TICKS - 1));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (coldRst)
    strb.cntClr |=> (tickCnt == '0));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       coldRst,
  input  logic       tickEn,
  input  logic       timeoutFlag,
  input  logic       offStrobe,
  input  logic       acRise,
  input  logic       settleHit,
  input  logic       holdHit,
  output seqStrobe_t strb,
  output pwrState_t  state,
  output logic       latchClr
);
  pwrState_t nextState;
  logic      pendWake;
  logic      wakeReq;
  logic      isOn;

  assign wakeReq = acRise | timeoutFlag;
  assign isOn    = (state != PS_OFF);

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      PS_OFF: begin
        strb.cntClr = 1'b1;
        if (wakeReq || pendWake) nextState = PS_SETTLE;
      end
      PS_SETTLE: begin
        if (offStrobe) nextState = PS_OFF;
        else if (tickEn) begin
          if (settleHit) begin
            nextState   = PS_HOLD;
            strb.cntClr = 1'b1;
          end else strb.cntInc = 1'b1;
        end
      end
      PS_HOLD: begin
        if (offStrobe) nextState = PS_OFF;
        else if (tickEn) begin
          if (holdHit) begin
            nextState   = PS_RUN;
            strb.cntClr = 1'b1;
          end else strb.cntInc = 1'b1;
        end
      end
      default: begin
        if (offStrobe) nextState = PS_OFF;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (coldRst) begin
      state    <= PS_OFF;
      pendWake <= 1'b0;
      latchClr <= 1'b0;
    end else begin
      state    <= nextState;
      pendWake <= isOn & offStrobe & wakeReq;
      latchClr <= isOn & offStrobe;
    end
  end

  // R6
  off_kills_chk: assert property (@(posedge clk) disable iff (coldRst)
    (isOn && offStrobe) |=> (state == PS_OFF && latchClr));
  // R7
  run_holds_chk: assert property (@(posedge clk) disable iff (coldRst)
    (state == PS_RUN && !offStrobe) |=> (state == PS_RUN));
  // R8
  idle_strobe_chk: assert property (@(posedge clk) disable iff (coldRst)
    (!isOn && offStrobe && !wakeReq && !pendWake) |=> (!latchClr && state == PS_OFF));
  // R9
  pend_wake_chk: assert property (@(posedge clk) disable iff (coldRst)
    (isOn && offStrobe && wakeReq) |=> ##1 (state == PS_SETTLE));
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pwrseq_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 512,
  parameter int unsigned RESET_TICKS  = 1536
) (
  input  logic clk,
  input  logic coldRst,
  input  logic tickEn,
  input  logic acIn,
  input  logic timeoutFlag,
  input  logic offStrobe,
  output logic supplyOnN,
  output logic stbyN,
  output logic resN,
  output logic latchClr
);
  seqStrobe_t strb;
  pwrState_t  state;
  logic       acRise;
  logic       settleHit;
  logic       holdHit;

  pwrseq_timer #(
    .SETTLE_TICKS(SETTLE_TICKS),
    .RESET_TICKS (RESET_TICKS)
  ) u_timer (
    .clk      (clk),
    .coldRst  (coldRst),
    .strb     (strb),
    .acIn     (acIn),
    .acRise   (acRise),
    .settleHit(settleHit),
    .holdHit  (holdHit)
  );

  pwrseq_ctrl u_ctrl (
    .clk        (clk),
    .coldRst    (coldRst),
    .tickEn     (tickEn),
    .timeoutFlag(timeoutFlag),
    .offStrobe  (offStrobe),
    .acRise     (acRise),
    .settleHit  (settleHit),
    .holdHit    (holdHit),
    .strb       (strb),
    .state      (state),
    .latchClr   (latchClr)
  );

  assign supplyOnN = (state == PS_OFF);
  assign stbyN     = (state == PS_HOLD) || (state == PS_RUN);
  assign resN      = (state == PS_RUN);

  // R5
  res_after_stby_chk: assert property (@(posedge clk) disable iff (coldRst)
    $rose(resN) |-> $past(stbyN));
  // R4
  stby_after_supply_chk: assert property (@(posedge clk) disable iff (coldRst)
    $rose(stbyN) |-> $past(!supplyOnN));
endmodule

// File: tb/pwr_sequencer_bench.sv
module pwr_sequencer_bench;
  localparam int S_T = 4;
  localparam int R_T = 6;

  logic clk = 1'b0;
  logic coldRst = 1'b1;
  logic tickEn = 1'b0;
  logic acIn = 1'b0;
  logic timeoutFlag = 1'b0;
  logic offStrobe = 1'b0;
  logic supplyOnN, stbyN, resN, latchClr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit randTick = 1'b0;
  int tickDiv = 0;

  always #5 clk = ~clk;

  pwr_sequencer #(.SETTLE_TICKS(S_T), .RESET_TICKS(R_T)) u_pwr_sequencer (
    .clk(clk), .coldRst(coldRst), .tickEn(tickEn), .acIn(acIn),
    .timeoutFlag(timeoutFlag), .offStrobe(offStrobe),
    .supplyOnN(supplyOnN), .stbyN(stbyN), .resN(resN), .latchClr(latchClr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model: phase 0 off, 1 settle, 2 reset, 3 running
  int mSt = 0, mCnt = 0;
  bit mPrevAc = 0, mPend = 0, mClr = 0;

  always @(posedge clk) begin
    if (coldRst) begin
      mSt = 0; mCnt = 0; mPrevAc = 0; mPend = 0; mClr = 0;
    end else begin
      bit wake, on, nPend, nClr;
      wake  = (acIn && !mPrevAc) || timeoutFlag;
      on    = (mSt != 0);
      nClr  = on && offStrobe;
      nPend = on && offStrobe && wake;
      case (mSt)
        0: if (wake || mPend) begin mSt = 1; mCnt = 0; end
        1, 2: begin
          if (offStrobe) mSt = 0;
          else if (tickEn) begin
            if (mCnt == ((mSt == 1) ? S_T : R_T) - 1) begin mSt = mSt + 1; mCnt = 0; end
            else mCnt = mCnt + 1;
          end
        end
        default: if (offStrobe) mSt = 0;
      endcase
      mPrevAc = acIn; mPend = nPend; mClr = nClr;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R1/R6 model supplyOnN", int'(supplyOnN), int'(mSt == 0));
      chk("R4 model stbyN", int'(stbyN), int'(mSt >= 2));
      chk("R5 model resN", int'(resN), int'(mSt == 3));
      chk("R6 model latchClr", int'(latchClr), int'(mClr));
    end
    if (randTick) tickEn = ($urandom % 3 == 0);
    else begin
      tickEn = (tickDiv == 0);
      tickDiv = (tickDiv + 1) % 3;
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic countSettle(input string tag);
    int n = 0;
    int guard = 0;
    while (!stbyN && guard < 500) begin
      if (tickEn) n++;
      cyc(); guard++;
    end
    chk(tag, n, S_T);
    chk("R4 reset still low", int'(resN), 0);
  endtask

  task automatic countHold();
    int n = 0;
    int guard = 0;
    while (!resN && guard < 500) begin
      if (tickEn) n++;
      cyc(); guard++;
    end
    chk("R5 reset-phase tick count", n, R_T);
    chk("R5 standby high when running", int'(stbyN), 1);
  endtask

  task automatic pulseOff();
    offStrobe = 1'b1; cyc(); offStrobe = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    // R1
    chk("R1 supplyOnN in reset", int'(supplyOnN), 1);
    chk("R1 stbyN in reset", int'(stbyN), 0);
    chk("R1 resN in reset", int'(resN), 0);
    coldRst = 1'b0; cyc();
    chk("R1 latchClr after reset", int'(latchClr), 0);
    chk("R1 still off after reset", int'(supplyOnN), 1);

    // R2 wake key edge
    acIn = 1'b1; cyc();
    chk("R2 supply on after key edge", int'(supplyOnN), 0);
    chk("R2 standby held", int'(stbyN), 0);
    countSettle("R4 settle tick count");
    countHold();

    // R7 key edge and timeout while running
    acIn = 1'b0; cyc(); acIn = 1'b1; timeoutFlag = 1'b1; cyc(); timeoutFlag = 1'b0;
    repeat (3) cyc();
    chk("R7 still running after key and timeout", int'(resN), 1);
    pulseOff();
    chk("R6 supply off", int'(supplyOnN), 1);
    chk("R6 standby low", int'(stbyN), 0);
    chk("R6 reset low", int'(resN), 0);
    chk("R6 latch clear pulse", int'(latchClr), 1);
    cyc();
    chk("R6 latch clear one cycle", int'(latchClr), 0);
    repeat (5) cyc();
    // R10 key held high, R7 no pending wake
    chk("R10 held key is not a wake", int'(supplyOnN), 1);

    // R8
    pulseOff();
    chk("R8 no clear when off", int'(latchClr), 0);
    chk("R8 stays off", int'(supplyOnN), 1);

    // R3 timeout wake
    timeoutFlag = 1'b1; cyc(); timeoutFlag = 1'b0;
    chk("R3 supply on after timeout", int'(supplyOnN), 0);
    chk("R3 standby held", int'(stbyN), 0);
    repeat (2) cyc();
    // R6 switch-off during settle
    pulseOff();
    chk("R6 off from settle", int'(supplyOnN), 1);
    chk("R6 clear from settle", int'(latchClr), 1);

    // R9 wake coinciding with switch-off
    acIn = 1'b0; cyc();
    acIn = 1'b1; cyc();
    countSettle("R4 settle count second run");
    countHold();
    acIn = 1'b0; cyc();
    acIn = 1'b1; offStrobe = 1'b1; cyc(); offStrobe = 1'b0;
    chk("R9 off for shutdown cycle", int'(supplyOnN), 1);
    chk("R9 clear pulse", int'(latchClr), 1);
    cyc();
    chk("R9 restarted supply", int'(supplyOnN), 0);
    chk("R9 restart in settle", int'(stbyN), 0);
    countSettle("R9 full settle after restart");

    // random traffic checked by the model
    randTick = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 8 == 0) acIn = ~acIn;
      timeoutFlag = ($urandom % 60 == 0);
      offStrobe = ($urandom % 30 == 0);
      cyc();
    end
    timeoutFlag = 1'b0; offStrobe = 1'b0;
    cyc();
    finishRun();
  end
endmodule